// File: doc/BRIEF.md
# Interrupt Fast Shadow Register Set

This block keeps a single saved copy of three 8-bit core registers: the status flags, the working register and the bank selector. The core pulses a strobe when it vectors to an interrupt, whatever the priority, or when it executes a call marked fast. On that strobe the current register values are latched into the shadow. When the core executes a return marked fast, the block presents the saved values with a one-cycle valid strobe, and the core writes them back into its working registers.

The shadow is only one entry deep. A later load replaces an earlier one. The case that matters most is a high-priority interrupt taken inside a low-priority handler: the high-priority entry overwrites the low-priority save. The block flags that case with a one-cycle warning pulse. Software has no path to read or write the shadow; it changes only through the core strobes.

Top module: `fast_shadow_set`

## Requirements
- R1: While rst_ni is low, and after it is released, restore_vld_o and overwrite_warn_o are 0 and all three restore outputs are 0. All three shadow fields reset to 0, so a fast return issued before any load restores zeros.
- R2: A cycle with irq_vec_i high loads status_i, wreg_i and bank_i into the shadow. This holds for either level of irq_hi_i (1 = high priority, 0 = low priority).
- R3: A cycle with fast_call_i high loads the shadow in the same way as an interrupt vector.
- R4: Unless fast_ret_i is high, restore_vld_o is 0 in the next cycle and the restore outputs keep their values. A fast return does not change the shadow, so a second fast return restores the same values again.
- R5: The shadow holds one entry. A restore returns the values from the most recent load, and every earlier load is lost.
- R6: If a load and a fast return fall in the same cycle, the restore returns the shadow contents from before that load. The new values are held for the next fast return.
- R7: A high-priority load (irq_vec_i=1, irq_hi_i=1) while a low-priority save is still unconsumed makes overwrite_warn_o high for exactly the next cycle. A low-priority save is unconsumed if it was the most recent load and no fast return has happened since it.
- R8: No warning is raised in three cases: a high-priority load when no low-priority save is pending; a pending save that was first replaced by a fast call or consumed by a fast return; a high-priority load in the same cycle as a fast return.
- R9: restore_vld_o is high exactly one cycle after fast_ret_i is high. In that cycle status_o, wreg_o and bank_o carry the restored fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| status_i | input | 8 | Current status register value |
| wreg_i | input | 8 | Current working register value |
| bank_i | input | 8 | Current bank-select register value |
| irq_vec_i | input | 1 | Core is vectoring to an interrupt this cycle |
| irq_hi_i | input | 1 | Priority of that interrupt (1 = high) |
| fast_call_i | input | 1 | Call with fast option this cycle |
| fast_ret_i | input | 1 | Return with fast option this cycle |
| status_o | output | 8 | Restored status value |
| wreg_o | output | 8 | Restored working register value |
| bank_o | output | 8 | Restored bank-select value |
| restore_vld_o | output | 1 | Restore values are valid this cycle |
| overwrite_warn_o | output | 1 | A high-priority entry overwrote a pending low-priority save |

## Verification
All results are due one clock edge after the stimulus: a load is visible to a fast return in the next cycle, and both restore_vld_o and overwrite_warn_o go high in the cycle after their causing strobe. The bench drives each step's inputs on a falling edge. It then steps a reference model through the same step and compares the outputs on the following falling edge, so each result is sampled exactly one rising edge after its cause. A sweep over all 16 combinations of the four strobes, with arithmetically varied data, covers the coincident cases along with the directed sequences.

// File: rtl/fsr_pkg.sv
package fsr_pkg;
  localparam int NREG = 3;
  localparam int IDX_STATUS = 0;
  localparam int IDX_WREG   = 1;
  localparam int IDX_BANK   = 2;
endpackage

// File: rtl/fsr_shadow.sv
module fsr_shadow
  import fsr_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         load_i,
  input  logic [NREG-1:0][DATA_W-1:0]  data_i,
  output logic [NREG-1:0][DATA_W-1:0]  data_o
);
  for (genvar g = 0; g < NREG; g++) begin : g_fld
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     q <= '0;
      else if (load_i) q <= data_i[g];
    end
    assign data_o[g] = q;
  end
endmodule

// File: rtl/fsr_restore.sv
module fsr_restore
  import fsr_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         ret_i,
  input  logic [NREG-1:0][DATA_W-1:0]  shadow_i,
  output logic [NREG-1:0][DATA_W-1:0]  data_o,
  output logic                         vld_o
);
  // shadow_i is the pre-load value, so a coincident load cannot leak in
  for (genvar g = 0; g < NREG; g++) begin : g_out
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    q <= '0;
      else if (ret_i) q <= shadow_i[g];
    end
    assign data_o[g] = q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vld_o <= 1'b0;
    else         vld_o <= ret_i;
  end
endmodule

// File: rtl/fsr_hazard.sv
module fsr_hazard (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic lo_load_i,
  input  logic hi_load_i,
  input  logic ret_i,
  output logic warn_o
);
  logic lo_pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     lo_pend_q <= 1'b0;
    else if (load_i) lo_pend_q <= lo_load_i;
    else if (ret_i)  lo_pend_q <= 1'b0;
  end

  // a coincident fast return consumes the low save before it is overwritten
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) warn_o <= 1'b0;
    else         warn_o <= hi_load_i & lo_pend_q & ~ret_i;
  end
endmodule

// File: rtl/fast_shadow_set.sv
module fast_shadow_set
  import fsr_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] status_i,
  input  logic [DATA_W-1:0] wreg_i,
  input  logic [DATA_W-1:0] bank_i,
  input  logic              irq_vec_i,
  input  logic              irq_hi_i,
  input  logic              fast_call_i,
  input  logic              fast_ret_i,
  output logic [DATA_W-1:0] status_o,
  output logic [DATA_W-1:0] wreg_o,
  output logic [DATA_W-1:0] bank_o,
  output logic              restore_vld_o,
  output logic              overwrite_warn_o
);
  logic                        load;
  logic                        lo_load;
  logic                        hi_load;
  logic [NREG-1:0][DATA_W-1:0] cur;
  logic [NREG-1:0][DATA_W-1:0] shadow;
  logic [NREG-1:0][DATA_W-1:0] rest;

  assign load    = irq_vec_i | fast_call_i;
  assign hi_load = irq_vec_i & irq_hi_i;
  assign lo_load = irq_vec_i & ~irq_hi_i;

  assign cur[IDX_STATUS] = status_i;
  assign cur[IDX_WREG]   = wreg_i;
  assign cur[IDX_BANK]   = bank_i;

  fsr_shadow #(.DATA_W(DATA_W)) u_shadow (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .data_i (cur),
    .data_o (shadow)
  );

  fsr_restore #(.DATA_W(DATA_W)) u_restore (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ret_i    (fast_ret_i),
    .shadow_i (shadow),
    .data_o   (rest),
    .vld_o    (restore_vld_o)
  );

  fsr_hazard u_hazard (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load),
    .lo_load_i (lo_load),
    .hi_load_i (hi_load),
    .ret_i     (fast_ret_i),
    .warn_o    (overwrite_warn_o)
  );

  assign status_o = rest[IDX_STATUS];
  assign wreg_o   = rest[IDX_WREG];
  assign bank_o   = rest[IDX_BANK];
endmodule

// File: rtl/fast_shadow_set_chk.sv
module fast_shadow_set_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [DATA_W-1:0] status_i,
  input logic [DATA_W-1:0] wreg_i,
  input logic [DATA_W-1:0] bank_i,
  input logic              irq_vec_i,
  input logic              irq_hi_i,
  input logic              fast_call_i,
  input logic              fast_ret_i,
  input logic [DATA_W-1:0] status_o,
  input logic [DATA_W-1:0] wreg_o,
  input logic [DATA_W-1:0] bank_o,
  input logic              restore_vld_o,
  input logic              overwrite_warn_o
);
  always_comb begin
    if (!rst_ni) begin
      AST_RESET_QUIET: assert (!restore_vld_o && !overwrite_warn_o); // R1
    end
  end

  AST_VLD_AFTER_RET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fast_ret_i |=> restore_vld_o); // R9

  AST_NO_RET_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fast_ret_i |=> (!restore_vld_o && $stable(status_o) && $stable(wreg_o) && $stable(bank_o))); // R4

  AST_WARN_NEEDS_HI: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(irq_vec_i && irq_hi_i) |=> !overwrite_warn_o); // R7

  AST_WARN_NOT_ON_RET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fast_ret_i |=> !overwrite_warn_o); // R8

  AST_WARN_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overwrite_warn_o |=> !overwrite_warn_o); // R7

  AST_RESTORE_LAST_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_vec_i || fast_call_i) ##1 fast_ret_i |=>
      (wreg_o == $past(wreg_i, 2) && status_o == $past(status_i, 2) && bank_o == $past(bank_i, 2))); // R5
endmodule

bind fast_shadow_set fast_shadow_set_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/fast_shadow_set_tb.sv
`timescale 1ns/1ps
module fast_shadow_set_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] status_i = '0, wreg_i = '0, bank_i = '0;
  logic       irq_vec_i = 0, irq_hi_i = 0, fast_call_i = 0, fast_ret_i = 0;
  logic [7:0] status_o, wreg_o, bank_o;
  logic       restore_vld_o, overwrite_warn_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [7:0] m_sh [3];
  logic [7:0] m_out [3];
  logic       m_vld, m_warn, m_pend;

  always #4 clk_i = ~clk_i;

  fast_shadow_set u_dut (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic compare(string req);
    chk({req, " vld"}, restore_vld_o, m_vld);
    chk({req, " warn"}, overwrite_warn_o, m_warn);
    chk({req, " status"}, status_o, m_out[0]);
    chk({req, " wreg"}, wreg_o, m_out[1]);
    chk({req, " bank"}, bank_o, m_out[2]);
  endtask

  // drive at a falling edge, advance the model, compare one rising edge later
  task automatic step(string req, bit vec, bit hi, bit call, bit ret,
                      logic [7:0] s, logic [7:0] w, logic [7:0] b);
    bit ld;
    irq_vec_i = vec; irq_hi_i = hi; fast_call_i = call; fast_ret_i = ret;
    status_i = s; wreg_i = w; bank_i = b;
    ld = vec | call;
    m_vld  = ret;
    m_warn = vec & hi & m_pend & ~ret;
    if (ret) m_out = m_sh;
    if (ld) begin
      m_pend = vec & ~hi;
      m_sh[0] = s; m_sh[1] = w; m_sh[2] = b;
    end else if (ret) m_pend = 0;
    @(negedge clk_i);
    compare(req);
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 3; k++) begin m_sh[k] = 0; m_out[k] = 0; end
    m_vld = 0; m_warn = 0; m_pend = 0;
    repeat (3) @(negedge clk_i);
    compare("R1 in reset");
    rst_ni = 1'b1;
    @(negedge clk_i);
    compare("R1 after reset");
    step("R1 restore zeros", 0, 0, 0, 1, 8'h11, 8'h22, 8'h33);
    step("R4 idle", 0, 0, 0, 0, 8'h44, 8'h55, 8'h66);
    // R2 low and high priority loads
    step("R2 lo load", 1, 0, 0, 0, 8'hA1, 8'hB2, 8'hC3);
    step("R2 lo ret", 0, 0, 0, 1, 8'h00, 8'h00, 8'h00);
    step("R4 no fast ret", 0, 0, 0, 0, 8'h01, 8'h02, 8'h03);
    step("R4 second ret same", 0, 0, 0, 1, 8'h09, 8'h09, 8'h09);
    step("R2 hi load", 1, 1, 0, 0, 8'h5A, 8'h6B, 8'h7C);
    step("R2 hi ret", 0, 0, 0, 1, 8'h00, 8'h00, 8'h00);
    // R3 fast call
    step("R3 call", 0, 0, 1, 0, 8'h13, 8'h57, 8'h9B);
    step("R3 ret", 0, 0, 0, 1, 8'h00, 8'h00, 8'h00);
    // R5 overwrite, R7 warning
    step("R5 lo load", 1, 0, 0, 0, 8'h10, 8'h20, 8'h30);
    step("R7 hi over lo", 1, 1, 0, 0, 8'hE0, 8'hE1, 8'hE2);
    step("R5 ret latest", 0, 0, 0, 1, 8'h00, 8'h00, 8'h00);
    // R6 coincident load and restore
    step("R6 coincide", 0, 0, 1, 1, 8'h77, 8'h88, 8'h99);
    step("R6 new held", 0, 0, 0, 1, 8'h00, 8'h00, 8'h00);
    // R8 cases
    step("R8 hi no pend", 1, 1, 0, 0, 8'h01, 8'h01, 8'h01);
    step("R8 lo", 1, 0, 0, 0, 8'h02, 8'h02, 8'h02);
    step("R8 consumed", 0, 0, 0, 1, 8'h00, 8'h00, 8'h00);
    step("R8 hi after consume", 1, 1, 0, 0, 8'h03, 8'h03, 8'h03);
    step("R8 lo again", 1, 0, 0, 0, 8'h04, 8'h04, 8'h04);
    step("R8 call replaces", 0, 0, 1, 0, 8'h05, 8'h05, 8'h05);
    step("R8 hi after call", 1, 1, 0, 0, 8'h06, 8'h06, 8'h06);
    step("R8 lo third", 1, 0, 0, 0, 8'h07, 8'h07, 8'h07);
    step("R8 hi with ret", 1, 1, 0, 1, 8'h08, 8'h08, 8'h08);
    // R9 near-exhaustive sweep over strobe combinations
    for (int i = 0; i < 512; i++) begin
      int ev;
      ev = (i * 7 + (i >> 4)) % 16;
      step("R9 sweep", ev[0], ev[1], ev[2], ev[3],
           8'((i * 37) ^ 8'h5C), 8'(i * 11 + 3), 8'((i * 73) >> 1));
    end
    step("R4 final idle", 0, 0, 0, 0, 8'h00, 8'h00, 8'h00);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule